// File: doc/BRIEF.md
# Capability-Checked Explicit Load/Store Unit

This unit carries out the load and store instructions of a capability-extended RISC-V core whose address type is named in the instruction. The decoder hands over a 5-bit access-kind field, a direction bit, an integer address and, for stores, the write data. Two bounds descriptors sit beside the request: the default data capability and an explicit capability operand. Each has a base, a length, a valid tag and load and store permissions. One bit of the kind field picks the descriptor that guards the access. The unit checks tag, permission and byte range against that descriptor. A legal access goes out on a valid/ready memory request port. Any other access ends at once, flagged as a fault or as an illegal instruction.

Load data that returns from memory is sign- or zero-extended to the size of the access. The unit holds one load-reserved / store-conditional reservation, which records both the address and the access size. Byte and halfword reservations are therefore exact and are not widened to a word. Every operation ends with a one-cycle completion pulse that carries the result word and the two error flags. Only one operation is in flight at a time.

Top module: `capls_unit`

## Requirements
- R1: Load kind field (bit 4 = reserve, bit 3 = bounds source, bit 2 = unsigned, bits 1-0 = size): with bit 4 clear, bits 1-0 request 1, 2, 4 or 8 bytes (size codes 0-3), and the data is sign-extended from the top bit of the access when bit 2 is 0 and zero-extended when it is 1.
- R2: A load with kind bit 4 set is a load-reserved. Its size code is bits 2-0 (0 byte, 1 halfword, 2 word, 3 doubleword, 4 capability-width of DATA_W bits), and byte to doubleword results are always sign-extended.
- R3: Store kind field: bit 4 selects store-conditional, bit 3 the bounds source and bits 2-0 the size, with the same 0-4 coding as R2. The memory request carries the write flag, the size code, the address and the write data.
- R4: Kind bit 3 = 0 checks the access against the default data capability, and 1 checks it against the explicit capability.
- R5: An access whose selected capability has its tag clear completes with the fault flag set.
- R6: A load without load permission, or a store without store permission, faults. The permission for the other direction has no effect on the result.
- R7: An access faults unless base <= address and address + bytes <= base + length. An access that ends exactly at base + length is allowed.
- R8: A faulting or illegal access issues no memory request.
- R9: Size codes 5, 6 and 7 in the load-reserved or store size field raise the illegal flag with no memory request and no fault.
- R10: A load-reserved that completes records its address and size. A store-conditional writes memory and returns 0 only when a reservation with the same address and the same size exists. Otherwise it returns 1 and issues no request.
- R11: Every legal store-conditional clears the reservation, whether it succeeds, fails or faults.
- R12: Reservations are exact at byte and halfword size. A store-conditional of a different size, or at a different address, fails.
- R13: A memory request holds its address, size and direction until ready is high. A load's completion pulse comes in the cycle after its response.
- R14: After reset the unit is ready, and it drives no memory request and no completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation taken this cycle |
| op_store | input | 1 | 1 = store family, 0 = load family |
| op_kind | input | 5 | Access-kind field |
| op_addr | input | ADDR_W | Integer byte address |
| op_wdata | input | DATA_W | Store data |
| ddc_base | input | ADDR_W | Default capability base |
| ddc_len | input | ADDR_W | Default capability length |
| ddc_tag | input | 1 | Default capability tag |
| ddc_ld | input | 1 | Default capability load permission |
| ddc_st | input | 1 | Default capability store permission |
| xcap_base | input | ADDR_W | Explicit capability base |
| xcap_len | input | ADDR_W | Explicit capability length |
| xcap_tag | input | 1 | Explicit capability tag |
| xcap_ld | input | 1 | Explicit capability load permission |
| xcap_st | input | 1 | Explicit capability store permission |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_size | output | 3 | Request size code |
| mem_req_wdata | output | DATA_W | Request write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DATA_W | Read data |
| done | output | 1 | Completion pulse |
| done_data | output | DATA_W | Load result or store-conditional status |
| done_fault | output | 1 | Access violated its capability |
| done_illegal | output | 1 | Reserved size code |

## Verification
The reservation compare and the capability check are both judged in the same acceptance cycle. The bench provokes this with a store-conditional whose address and size match a live reservation but whose selected capability excludes that address. The expected outcome is a fault, no memory write, and a reservation that is gone. A later store-conditional that fails with status 1 shows the reservation was cleared. The bench also offers reserved size codes on operations whose bounds would fault, and expects only the illegal flag.

// File: rtl/capls_pkg.sv
package capls_pkg;

    localparam int KIND_W = 5;
    localparam int SZ_W   = 3;
    localparam logic [SZ_W-1:0] SZ_MAX_LEGAL = 3'd4;

    // Decoded access descriptor
    typedef struct packed {
        logic            is_st;
        logic            rsv;     // load-reserved / store-conditional
        logic            use_x;   // explicit capability guards the access
        logic            uns;     // zero-extend
        logic [SZ_W-1:0] sz;      // log2 bytes
        logic            bad;     // reserved size code
    } acc_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FIN   = 2'd3
    } st_e;

    function automatic acc_t decode_kind(input logic is_st, input logic [KIND_W-1:0] k);
        acc_t a;
        a.is_st = is_st;
        a.rsv   = k[4];
        a.use_x = k[3];
        if (!is_st && !k[4]) begin
            a.uns = k[2];
            a.sz  = {1'b0, k[1:0]};
        end else begin
            a.uns = 1'b0;
            a.sz  = k[2:0];
        end
        a.bad = (a.sz > SZ_MAX_LEGAL);
        return a;
    endfunction

    function automatic logic [4:0] size_bytes(input logic [SZ_W-1:0] sz);
        return 5'd1 << sz;
    endfunction

endpackage

// File: rtl/capls_decode.sv
module capls_decode
    import capls_pkg::*;
(
    input  logic              is_st,
    input  logic [KIND_W-1:0] kind,
    output acc_t              acc,
    output logic [4:0]        nbytes
);
    always_comb begin
        acc    = decode_kind(is_st, kind);
        nbytes = acc.bad ? 5'd0 : size_bytes(acc.sz);
    end
endmodule

// File: rtl/capls_bounds.sv
module capls_bounds #(
    parameter int ADDR_W = 32
) (
    input  logic              is_st,
    input  logic              use_x,
    input  logic [ADDR_W-1:0] addr,
    input  logic [4:0]        nbytes,
    input  logic [ADDR_W-1:0] d_base,
    input  logic [ADDR_W-1:0] d_len,
    input  logic              d_tag,
    input  logic              d_ld,
    input  logic              d_st,
    input  logic [ADDR_W-1:0] x_base,
    input  logic [ADDR_W-1:0] x_len,
    input  logic              x_tag,
    input  logic              x_ld,
    input  logic              x_st,
    output logic              ok
);
    localparam int EXT_W = ADDR_W + 1;

    logic [ADDR_W-1:0] base, len;
    logic              tag, perm;
    logic [EXT_W-1:0]  end_acc, end_cap;
    logic              lo_ok, hi_ok;

    always_comb begin
        base = use_x ? x_base : d_base;
        len  = use_x ? x_len  : d_len;
        tag  = use_x ? x_tag  : d_tag;
        if (is_st) perm = use_x ? x_st : d_st;
        else       perm = use_x ? x_ld : d_ld;
        end_acc = {1'b0, addr} + EXT_W'(nbytes);
        end_cap = {1'b0, base} + {1'b0, len};
        lo_ok   = (addr >= base);
        hi_ok   = (end_acc <= end_cap);
        ok      = tag && perm && lo_ok && hi_ok;
    end
endmodule

// File: rtl/capls_resv.sv
module capls_resv
    import capls_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic [SZ_W-1:0]   set_sz,
    input  logic              clr,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [SZ_W-1:0]   chk_sz,
    output logic              match,
    output logic              held
);
    logic [ADDR_W-1:0] r_addr;
    logic [SZ_W-1:0]   r_sz;

    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= 1'b0;
            r_addr <= '0;
            r_sz   <= '0;
        end else if (set) begin
            held   <= 1'b1;
            r_addr <= set_addr;
            r_sz   <= set_sz;
        end else if (clr) begin
            held   <= 1'b0;
        end
    end

    assign match = held && (r_addr == chk_addr) && (r_sz == chk_sz);
endmodule

// File: rtl/capls_extend.sv
module capls_extend
    import capls_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SZ_W-1:0]   sz,
    input  logic              uns,
    output logic [DATA_W-1:0] dout
);
    localparam int NSUB = 4;   // byte, half, word, double

    logic [DATA_W-1:0] ext [NSUB];

    for (genvar g = 0; g < NSUB; g++) begin : g_ext
        localparam int W = 8 << g;
        always_comb begin
            ext[g] = {{(DATA_W-W){~uns & din[W-1]}}, din[W-1:0]};
        end
    end

    always_comb begin
        if (sz < SZ_W'(NSUB)) dout = ext[sz[1:0]];
        else                  dout = din;
    end
endmodule

// File: rtl/capls_unit.sv
module capls_unit
    import capls_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic              op_store,
    input  logic [4:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_wdata,
    input  logic [ADDR_W-1:0] ddc_base,
    input  logic [ADDR_W-1:0] ddc_len,
    input  logic              ddc_tag,
    input  logic              ddc_ld,
    input  logic              ddc_st,
    input  logic [ADDR_W-1:0] xcap_base,
    input  logic [ADDR_W-1:0] xcap_len,
    input  logic              xcap_tag,
    input  logic              xcap_ld,
    input  logic              xcap_st,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [2:0]        mem_req_size,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              done,
    output logic [DATA_W-1:0] done_data,
    output logic              done_fault,
    output logic              done_illegal
);
    st_e               st_q;
    acc_t              acc_d, acc_q;
    logic [4:0]        nbytes;
    logic              bounds_ok;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, res_q, ext_data;
    logic              fault_q, ill_q;
    logic              take, sc_new, rsv_match, rsv_held, rsv_set;

    capls_decode u_dec (
        .is_st  (op_store),
        .kind   (op_kind),
        .acc    (acc_d),
        .nbytes (nbytes)
    );

    capls_bounds #(.ADDR_W(ADDR_W)) u_bnd (
        .is_st  (op_store),
        .use_x  (acc_d.use_x),
        .addr   (op_addr),
        .nbytes (nbytes),
        .d_base (ddc_base),
        .d_len  (ddc_len),
        .d_tag  (ddc_tag),
        .d_ld   (ddc_ld),
        .d_st   (ddc_st),
        .x_base (xcap_base),
        .x_len  (xcap_len),
        .x_tag  (xcap_tag),
        .x_ld   (xcap_ld),
        .x_st   (xcap_st),
        .ok     (bounds_ok)
    );

    assign take    = op_valid && (st_q == ST_IDLE);
    assign sc_new  = take && acc_d.is_st && acc_d.rsv && !acc_d.bad;
    assign rsv_set = (st_q == ST_WAIT) && mem_rsp_valid && acc_q.rsv;

    capls_resv #(.ADDR_W(ADDR_W)) u_rsv (
        .clk      (clk),
        .rst      (rst),
        .set      (rsv_set),
        .set_addr (addr_q),
        .set_sz   (acc_q.sz),
        .clr      (sc_new),
        .chk_addr (op_addr),
        .chk_sz   (acc_d.sz),
        .match    (rsv_match),
        .held     (rsv_held)
    );

    capls_extend #(.DATA_W(DATA_W)) u_ext (
        .din  (mem_rsp_data),
        .sz   (acc_q.sz),
        .uns  (acc_q.uns),
        .dout (ext_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            acc_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            res_q   <= '0;
            fault_q <= 1'b0;
            ill_q   <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (take) begin
                        acc_q   <= acc_d;
                        addr_q  <= op_addr;
                        wdata_q <= op_wdata;
                        res_q   <= '0;
                        fault_q <= 1'b0;
                        ill_q   <= 1'b0;
                        if (acc_d.bad) begin
                            ill_q <= 1'b1;
                            st_q  <= ST_FIN;
                        end else if (!bounds_ok) begin
                            fault_q <= 1'b1;
                            st_q    <= ST_FIN;
                        end else if (acc_d.is_st && acc_d.rsv && !rsv_match) begin
                            res_q <= DATA_W'(1);
                            st_q  <= ST_FIN;
                        end else begin
                            st_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (mem_req_ready) st_q <= acc_q.is_st ? ST_FIN : ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        res_q <= ext_data;
                        st_q  <= ST_FIN;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign op_ready      = (st_q == ST_IDLE);
    assign mem_req_valid = (st_q == ST_ISSUE);
    assign mem_req_we    = acc_q.is_st;
    assign mem_req_addr  = addr_q;
    assign mem_req_size  = acc_q.sz;
    assign mem_req_wdata = wdata_q;
    assign done          = (st_q == ST_FIN);
    assign done_data     = res_q;
    assign done_fault    = done && fault_q;
    assign done_illegal  = done && ill_q;

endmodule

// File: rtl/capls_chk.sv
module capls_chk
    import capls_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input st_e               st,
    input logic              op_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_we,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [2:0]        mem_req_size,
    input logic              mem_rsp_valid,
    input logic              done,
    input logic              done_fault,
    input logic              done_illegal,
    input logic              rsv_held,
    input logic              cur_sc
);
    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_size) && $stable(mem_req_we));

    // R13
    rsp_done_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT) && mem_rsp_valid |=> done && !done_fault && !done_illegal);

    // R8
    fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done && (done_fault || done_illegal) |-> !mem_req_valid && !$past(mem_req_valid));

    // R9
    illegal_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done_illegal |-> !done_fault);

    // R11
    sc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        done && cur_sc && !done_illegal |-> !rsv_held);

    // R14
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        op_ready |-> !mem_req_valid && !done);
endmodule

bind capls_unit capls_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .st            (st_q),
    .op_ready      (op_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_size  (mem_req_size),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .done_fault    (done_fault),
    .done_illegal  (done_illegal),
    .rsv_held      (rsv_held),
    .cur_sc        (acc_q.is_st && acc_q.rsv)
);

// File: tb/tb_capls_unit.sv
module tb_capls_unit;
    localparam int AW = 16;
    localparam int DW = 128;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          op_valid = 0, op_store = 0;
    logic [4:0]    op_kind = 0;
    logic [AW-1:0] op_addr = 0;
    logic [DW-1:0] op_wdata = 0;
    logic [AW-1:0] ddc_base, ddc_len, xcap_base, xcap_len;
    logic          ddc_tag, ddc_ld, ddc_st, xcap_tag, xcap_ld, xcap_st;
    logic          op_ready, mem_req_valid, mem_req_we, done, done_fault, done_illegal;
    logic          mem_req_ready;
    logic [AW-1:0] mem_req_addr;
    logic [2:0]    mem_req_size;
    logic [DW-1:0] mem_req_wdata, done_data;
    logic          mem_rsp_valid = 0;
    logic [DW-1:0] mem_rsp_data = 0;

    capls_unit #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

    int total = 0, failed = 0;
    int cyc = 0, last_rsp = 0, req_cnt = 0;
    logic [1:0]    rcnt = 0;
    logic          seen_we;
    logic [2:0]    seen_sz;
    logic [AW-1:0] seen_addr;
    logic [DW-1:0] seen_wd;

    assign mem_req_ready = (rcnt == 2'd3);

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        logic [DW-1:0] p;
        logic [15:0] w;
        w = a * 16'h9e37 ^ 16'hc3a5;
        for (int i = 0; i < DW/16; i++) p[16*i +: 16] = w ^ (16'h1357 * i[15:0]);
        return p;
    endfunction

    function automatic logic [DW-1:0] ext(input logic [DW-1:0] d, input int sz, input bit u);
        int w;
        logic [DW-1:0] m, r;
        if (sz >= 4) return d;
        w = 8 << sz;
        m = (DW'(1) << w) - 1;
        r = d & m;
        if (!u && d[w-1]) r = r | ~m;
        return r;
    endfunction

    // memory model: ready one cycle in four, read data next cycle
    always @(posedge clk) begin
        cyc <= cyc + 1;
        rcnt <= rcnt + 1;
        if (mem_rsp_valid) last_rsp <= cyc;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            req_cnt   <= req_cnt + 1;
            seen_we   <= mem_req_we;
            seen_sz   <= mem_req_size;
            seen_addr <= mem_req_addr;
            seen_wd   <= mem_req_wdata;
            if (!mem_req_we) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= pat(mem_req_addr);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [DW-1:0] r_data;
    bit r_fault, r_ill;
    int r_reqs, r_cyc;

    task automatic run_op(input bit s, input logic [4:0] k, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        int base_req, t;
        @(negedge clk);
        op_valid = 1; op_store = s; op_kind = k; op_addr = a; op_wdata = wd;
        base_req = req_cnt;
        @(negedge clk);
        op_valid = 0;
        t = 0;
        while (!done && t < 100) begin @(negedge clk); t++; end
        chk(t < 100, "R13 completion", DW'(t), DW'(0));
        r_data = done_data; r_fault = done_fault; r_ill = done_illegal;
        r_reqs = req_cnt - base_req; r_cyc = cyc;
    endtask

    task automatic caps_default();
        ddc_base = 16'h1000; ddc_len = 16'h0100; ddc_tag = 1; ddc_ld = 1; ddc_st = 1;
        xcap_base = 16'h2000; xcap_len = 16'h0040; xcap_tag = 1; xcap_ld = 1; xcap_st = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failed++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        logic [AW-1:0] a, base;
        caps_default();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R14 reset state
        chk(op_ready && !mem_req_valid && !done, "R14 reset",
            DW'({op_ready, mem_req_valid, done}), DW'(3'b100));

        // R1 R4 ordinary loads, every kind code
        for (int k = 0; k < 16; k++) begin
            base = k[3] ? xcap_base : ddc_base;
            a = base + AW'(8 * (k & 7)) + AW'(k & 1) * 0;
            run_op(0, 5'(k), a, '0);
            chk(!r_fault && !r_ill && r_reqs == 1 && seen_sz == 3'(k & 3) && !seen_we,
                "R1 load request", DW'({r_fault, r_ill, seen_sz}), DW'(k & 3));
            chk(r_data == ext(pat(a), k & 3, k[2]), "R1 load extension",
                r_data, ext(pat(a), k & 3, k[2]));
            chk(r_cyc == last_rsp + 1, "R13 done after response", DW'(r_cyc), DW'(last_rsp + 1));
        end

        // R2 R9 load-reserved codes
        for (int k = 16; k < 32; k++) begin
            int sz;
            sz = k & 7;
            base = k[3] ? xcap_base : ddc_base;
            a = base + 16;
            run_op(0, 5'(k), a, '0);
            if (sz <= 4) begin
                chk(!r_ill && r_reqs == 1 && seen_sz == 3'(sz), "R2 reserved load size",
                    DW'(seen_sz), DW'(sz));
                chk(r_data == ext(pat(a), sz, 0), "R2 reserved load sign", r_data, ext(pat(a), sz, 0));
            end else begin
                chk(r_ill && !r_fault && r_reqs == 0, "R9 reserved size code",
                    DW'({r_ill, r_fault, r_reqs[0]}), DW'(3'b100));
            end
        end

        // clear any reservation left over
        run_op(1, 5'b10000, 16'h1000, '0);

        // R3 R9 R10 store codes, no reservation held
        for (int k = 0; k < 32; k++) begin
            int sz;
            logic [DW-1:0] wd;
            sz = k & 7;
            base = k[3] ? xcap_base : ddc_base;
            a = base + 32;
            wd = pat(AW'(k + 7));
            run_op(1, 5'(k), a, wd);
            if (sz > 4) begin
                chk(r_ill && !r_fault && r_reqs == 0, "R9 reserved store size",
                    DW'({r_ill, r_fault, r_reqs[0]}), DW'(3'b100));
            end else if (k[4]) begin
                chk(r_data == 1 && r_reqs == 0, "R10 conditional store without reservation",
                    r_data, DW'(1));
            end else begin
                chk(r_reqs == 1 && seen_we && seen_sz == 3'(sz) && seen_addr == a && seen_wd == wd,
                    "R3 store request", DW'({seen_we, seen_sz}), DW'({1'b1, 3'(sz)}));
            end
        end

        // R4 source selection: address inside default, outside explicit
        run_op(0, 5'b01010, 16'h1010, '0);
        chk(r_fault && r_reqs == 0, "R4 explicit source faults", DW'(r_fault), DW'(1));
        run_op(0, 5'b00010, 16'h1010, '0);
        chk(!r_fault && r_reqs == 1, "R4 default source passes", DW'(r_fault), DW'(0));
        run_op(1, 5'b00010, 16'h2010, '0);
        chk(r_fault && r_reqs == 0, "R4 store default source faults", DW'(r_fault), DW'(1));

        // R5 tag
        ddc_tag = 0;
        run_op(0, 5'b00010, 16'h1010, '0);
        chk(r_fault && r_reqs == 0, "R5 untagged default", DW'(r_fault), DW'(1));
        run_op(0, 5'b01010, 16'h2010, '0);
        chk(!r_fault && r_reqs == 1, "R5 tagged explicit unaffected", DW'(r_fault), DW'(0));
        caps_default();

        // R6 permissions
        ddc_ld = 0;
        run_op(0, 5'b00010, 16'h1010, '0);
        chk(r_fault && r_reqs == 0, "R6 no load permission", DW'(r_fault), DW'(1));
        run_op(1, 5'b00010, 16'h1010, '0);
        chk(!r_fault && r_reqs == 1, "R6 store ignores load permission", DW'(r_fault), DW'(0));
        ddc_ld = 1; xcap_st = 0;
        run_op(1, 5'b01010, 16'h2010, '0);
        chk(r_fault && r_reqs == 0, "R6 no store permission", DW'(r_fault), DW'(1));
        run_op(0, 5'b01010, 16'h2010, '0);
        chk(!r_fault && r_reqs == 1, "R6 load ignores store permission", DW'(r_fault), DW'(0));
        caps_default();

        // R7 R8 bounds sweep near both edges of the explicit capability
        for (int sz = 0; sz < 4; sz++) begin
            for (int off = -3; off <= 3; off++) begin
                for (int edge_sel = 0; edge_sel < 2; edge_sel++) begin
                    int ai, n;
                    bit ok;
                    n = 1 << sz;
                    ai = (edge_sel == 0) ? 32'h2000 + off : 32'h2040 - n + off;
                    ok = (ai >= 32'h2000) && (ai + n <= 32'h2040);
                    run_op(0, 5'(8 + sz), AW'(ai), '0);
                    chk(r_fault == !ok && r_reqs == (ok ? 1 : 0), "R7 R8 bounds",
                        DW'({r_fault, r_reqs[1:0]}), DW'({!ok, ok ? 2'd1 : 2'd0}));
                end
            end
        end

        // R10 R11 reservation success then reuse
        run_op(1, 5'b10000, 16'h1000, '0);
        run_op(0, 5'b10010, 16'h1040, '0);
        run_op(1, 5'b10010, 16'h1040, 128'h55);
        chk(r_data == 0 && r_reqs == 1 && seen_we && seen_wd == 128'h55, "R10 conditional store succeeds",
            r_data, DW'(0));
        run_op(1, 5'b10010, 16'h1040, 128'h66);
        chk(r_data == 1 && r_reqs == 0, "R11 reservation cleared after success", r_data, DW'(1));

        // R12 byte reservation vs halfword conditional store
        run_op(0, 5'b10000, 16'h1050, '0);
        run_op(1, 5'b10001, 16'h1050, '0);
        chk(r_data == 1 && r_reqs == 0, "R12 size mismatch fails", r_data, DW'(1));
        run_op(0, 5'b10001, 16'h1052, '0);
        run_op(1, 5'b10001, 16'h1054, '0);
        chk(r_data == 1 && r_reqs == 0, "R12 address mismatch fails", r_data, DW'(1));
        run_op(0, 5'b10000, 16'h1061, '0);
        run_op(1, 5'b10000, 16'h1061, 128'h7);
        chk(r_data == 0 && r_reqs == 1 && seen_sz == 3'd0, "R12 native byte pair", r_data, DW'(0));
        run_op(0, 5'b10001, 16'h1062, '0);
        run_op(1, 5'b10001, 16'h1062, 128'h9);
        chk(r_data == 0 && r_reqs == 1 && seen_sz == 3'd1, "R12 native halfword pair", r_data, DW'(0));

        // R11 matching reservation but faulting conditional store
        run_op(0, 5'b10010, 16'h1070, '0);
        run_op(1, 5'b11010, 16'h1070, '0);
        chk(r_fault && r_reqs == 0, "R11 fault wins over match", DW'(r_fault), DW'(1));
        run_op(1, 5'b10010, 16'h1070, '0);
        chk(r_data == 1 && r_reqs == 0, "R11 reservation cleared by fault", r_data, DW'(1));

        // R9 reserved size beats out-of-bounds
        run_op(1, 5'b01111, 16'h0000, '0);
        chk(r_ill && !r_fault && r_reqs == 0, "R9 illegal over fault",
            DW'({r_ill, r_fault}), DW'(2'b10));

        // R2 quad load-reserved returns full width
        run_op(0, 5'b11100, 16'h2020, '0);
        chk(r_data == pat(16'h2020) && seen_sz == 3'd4, "R2 capability-width reserve", r_data, pat(16'h2020));

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule